// File: doc/BRIEF.md
# Daisy-Chain Serial Configuration Receiver

This block is the configuration front end of one device in a chain of devices that all load from one serial bitstream. Bits arrive on `din` and are sampled on the rising edge of `cclk`. The block finds the header, which is a fixed 8-bit sync pattern followed by a 24-bit length field. It copies that header onward on `dout` so that the next device in the chain can parse the same header. It then assembles its own configuration frames and hands each one to a configuration store through a write strobe.

While it consumes its own frames, the block drives `dout` high. A downstream device therefore never sees a frame start bit. Once the block has written all of its frames, it forwards every further bit on `dout`, because those bits belong to devices further down the chain. A counter of the bits that follow the length field is compared with the length value, and `done` rises when the two are equal. From then on `done` stays high and `dout` stays high until the program input is pulled low.

The write port carries data out of the block, but it has no ready signal and applies no back-pressure. The serial input cannot be stalled, so the store must accept every `wr_valid` pulse in the cycle in which it is presented. Each pulse lasts one cycle, and two pulses are always at least `START_BITS + FRAME_BITS` cycles apart.

Top module: `cfg_chain_rx`

## Requirements
- R1: While `prog_n` is low (asynchronous, active low), the outputs are `dout`=1, `done`=0, `err`=0 and `wr_valid`=0. After `prog_n` returns high, the block waits for a new header, and the first frame it stores is written at address 0.
- R2: `din` is sampled on the rising edge of `cclk`. `dout` changes only on the falling edge. A bit relayed on `dout` appears at the falling edge that follows the rising edge that sampled it.
- R3: The line idles at 1. The sync pattern is 8'b1111_0010, sent left bit first, and it is recognised as at least four 1s followed by the bits 0, 0, 1, 0. Every bit sampled while the block waits for or checks the pattern is relayed on `dout`.
- R4: If any of the three bits after the first 0 differs from the pattern, the block sets `err` and returns to waiting. `err` stays high until `prog_n` is pulled low, and the offending bit is still relayed.
- R5: A 24-bit length follows the sync pattern directly, most significant bit first. It gives the number of bits that follow the length field, and all 24 of its bits are relayed on `dout`.
- R6: Each local frame is `START_BITS` (default 2) zero bits followed by `FRAME_BITS` (default 16) data bits. While the local frames are loading, `dout` is 1.
- R7: `wr_valid` is a one-cycle pulse that is set by the rising edge sampling the last data bit of a frame. `wr_addr` counts 0, 1, … `NUM_FRAMES`-1 in order. In `wr_data`, the first data bit received is the most significant bit.
- R8: If a start-bit position holds a 1, the block sets `err` and returns to waiting, and bits after that are relayed again.
- R9: Once `NUM_FRAMES` frames have been written, every further bit is relayed on `dout` until the length is reached.
- R10: `done` is set by the rising edge on which the count of bits after the length field equals the length. This also applies in the middle of a frame, and such a partial frame is never written. A length of 0 sets `done` on the edge of the last length bit.
- R11: After `done` is set, it stays high and `dout` stays 1 whatever arrives on `din`, until `prog_n` is pulled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cclk | input | 1 | Configuration bit clock |
| prog_n | input | 1 | Active-low program/reset, asynchronous |
| din | input | 1 | Serial bitstream in |
| dout | output | 1 | Serial bitstream to the next device in the chain |
| wr_valid | output | 1 | One-cycle frame write strobe |
| wr_addr | output | ADDR_W | Frame slot being written |
| wr_data | output | FRAME_BITS | Assembled frame, first received bit in MSB |
| done | output | 1 | Full length received |
| err | output | 1 | Sync-pattern or start-bit error seen |

## Verification
The main test is a complete chained stream: idle ones, the header, four frames with mixed data, 20 overflow bits with zeros mixed in, and trailing zeros. It separates the three `dout` regimes (relay, held high, relay again) and confirms that zeros after `done` are hidden. A stream with a broken sync pattern, followed by a valid header whose length ends in the middle of the first frame, separates sync checking from length-limited completion and shows that a partial frame is dropped. A zero length, a start bit of 1, and a program pulse during loading cover the edge exits of the state machine. A half-cycle stability probe on every bit ties `dout` changes to the falling edge.

// File: rtl/cfg_chain_pkg.sv
package cfg_chain_pkg;
  // sync pattern: a run of leading ones, then a tail checked bit by bit
  localparam logic [7:0] SYNC_WORD = 8'b1111_0010;
  localparam int         SYNC_LEAD = 4;
  localparam int         SYNC_TAIL = 3;

  typedef enum logic [2:0] {
    ST_WAIT,   // line idle, counting ones
    ST_SYNC,   // checking sync tail bits
    ST_LEN,    // shifting in the length field
    ST_LOAD,   // consuming local frames
    ST_PASS,   // local store full, forwarding
    ST_DONE    // length reached
  } cfg_state_e;
endpackage

// File: rtl/cfg_len_shift.sv
module cfg_len_shift #(
  parameter int LEN_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             bit_in,
  output logic             last,
  output logic [LEN_W-1:0] value_next,
  output logic [LEN_W-1:0] value_q
);
  localparam int CW = $clog2(LEN_W);

  logic [CW-1:0] idx_q;

  assign value_next = {value_q[LEN_W-2:0], bit_in};
  assign last       = en && (idx_q == CW'(LEN_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      value_q <= '0;
    end else if (en) begin
      value_q <= value_next;
      idx_q   <= last ? '0 : idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/cfg_frame_asm.sv
module cfg_frame_asm #(
  parameter int FRAME_BITS = 16,
  parameter int START_BITS = 2,
  parameter int NUM_FRAMES = 4,
  parameter int ADDR_W     = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_load,
  input  logic                  bit_in,
  output logic                  start_err,
  output logic                  store_last,
  output logic                  wr_valid,
  output logic [ADDR_W-1:0]     wr_addr,
  output logic [FRAME_BITS-1:0] wr_data
);
  localparam int SLOT = START_BITS + FRAME_BITS;
  localparam int PW   = $clog2(SLOT);

  logic [PW-1:0]         pos_q;
  logic [ADDR_W-1:0]     slot_q;
  logic [FRAME_BITS-1:0] acc_q;
  logic [FRAME_BITS-1:0] acc_next;
  logic                  in_start;
  logic                  frame_end;

  assign in_start   = pos_q < PW'(START_BITS);
  assign start_err  = in_load && in_start && bit_in;
  assign frame_end  = in_load && (pos_q == PW'(SLOT - 1));
  assign store_last = frame_end && (slot_q == ADDR_W'(NUM_FRAMES - 1));
  assign acc_next   = {acc_q[FRAME_BITS-2:0], bit_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q    <= '0;
      slot_q   <= '0;
      acc_q    <= '0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_valid <= frame_end;
      if (frame_end) begin
        wr_addr <= slot_q;
        wr_data <= acc_next;
      end
      if (!in_load) begin
        pos_q  <= '0;
        slot_q <= '0;
      end else begin
        pos_q <= frame_end ? '0 : pos_q + 1'b1;
        if (!in_start) acc_q <= acc_next;
        if (frame_end) slot_q <= slot_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfg_relay.sv
module cfg_relay (
  input  logic clk,
  input  logic rst_n,
  input  logic fwd_en,
  input  logic bit_in,
  output logic dout
);
  logic fwd_q;

  // capture on the sampling edge, launch on the following falling edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fwd_q <= 1'b1;
    else        fwd_q <= fwd_en ? bit_in : 1'b1;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) dout <= 1'b1;
    else        dout <= fwd_q;
  end
endmodule

// File: rtl/cfg_chain_rx.sv
module cfg_chain_rx
  import cfg_chain_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int START_BITS = 2,
  parameter int NUM_FRAMES = 4,
  parameter int LEN_W      = 24,
  localparam int ADDR_W    = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic                  cclk,
  input  logic                  prog_n,
  input  logic                  din,
  output logic                  dout,
  output logic                  wr_valid,
  output logic [ADDR_W-1:0]     wr_addr,
  output logic [FRAME_BITS-1:0] wr_data,
  output logic                  done,
  output logic                  err
);
  localparam int OW = $clog2(SYNC_LEAD + 1);
  localparam int TW = $clog2(SYNC_TAIL + 1);
  localparam logic [SYNC_TAIL-1:0] TAIL_PAT = SYNC_WORD[SYNC_TAIL-1:0];

  cfg_state_e           state_q, state_d;
  logic [OW-1:0]        ones_q, ones_d;
  logic [TW-1:0]        tidx_q, tidx_d;
  logic [SYNC_TAIL-1:0] texp_q, texp_d;
  logic [LEN_W-1:0]     pay_q, pay_d, pay_inc;
  logic                 err_q, err_d;

  logic                 len_last;
  logic [LEN_W-1:0]     len_next, len_val;
  logic                 start_err, store_last;
  logic                 fwd_en, hit;

  cfg_len_shift #(.LEN_W(LEN_W)) u_len (
    .clk        (cclk),
    .rst_n      (prog_n),
    .en         (state_q == ST_LEN),
    .bit_in     (din),
    .last       (len_last),
    .value_next (len_next),
    .value_q    (len_val)
  );

  cfg_frame_asm #(
    .FRAME_BITS (FRAME_BITS),
    .START_BITS (START_BITS),
    .NUM_FRAMES (NUM_FRAMES),
    .ADDR_W     (ADDR_W)
  ) u_asm (
    .clk        (cclk),
    .rst_n      (prog_n),
    .in_load    (state_q == ST_LOAD),
    .bit_in     (din),
    .start_err  (start_err),
    .store_last (store_last),
    .wr_valid   (wr_valid),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data)
  );

  assign fwd_en = (state_q == ST_WAIT) || (state_q == ST_SYNC) ||
                  (state_q == ST_LEN)  || (state_q == ST_PASS);

  cfg_relay u_relay (
    .clk    (cclk),
    .rst_n  (prog_n),
    .fwd_en (fwd_en),
    .bit_in (din),
    .dout   (dout)
  );

  assign pay_inc = pay_q + 1'b1;
  assign hit     = (pay_inc == len_val);

  always_comb begin
    state_d = state_q;
    ones_d  = ones_q;
    tidx_d  = tidx_q;
    texp_d  = texp_q;
    pay_d   = pay_q;
    err_d   = err_q;
    unique case (state_q)
      ST_WAIT: begin
        if (din) begin
          if (ones_q != OW'(SYNC_LEAD)) ones_d = ones_q + 1'b1;
        end else begin
          ones_d = '0;
          if (ones_q == OW'(SYNC_LEAD)) begin
            state_d = ST_SYNC;
            tidx_d  = '0;
            texp_d  = TAIL_PAT;
          end
        end
      end
      ST_SYNC: begin
        if (din != texp_q[SYNC_TAIL-1]) begin
          err_d   = 1'b1;
          state_d = ST_WAIT;
        end else if (tidx_q == TW'(SYNC_TAIL - 1)) begin
          state_d = ST_LEN;
        end else begin
          tidx_d = tidx_q + 1'b1;
          texp_d = {texp_q[SYNC_TAIL-2:0], 1'b0};
        end
      end
      ST_LEN: begin
        pay_d = '0;
        if (len_last) state_d = (len_next == '0) ? ST_DONE : ST_LOAD;
      end
      ST_LOAD: begin
        pay_d = pay_inc;
        if (hit)             state_d = ST_DONE;
        else if (start_err) begin
          err_d   = 1'b1;
          state_d = ST_WAIT;
        end
        else if (store_last) state_d = ST_PASS;
      end
      ST_PASS: begin
        pay_d = pay_inc;
        if (hit) state_d = ST_DONE;
      end
      ST_DONE: state_d = ST_DONE;
      default: state_d = ST_WAIT;
    endcase
  end

  always_ff @(posedge cclk or negedge prog_n) begin
    if (!prog_n) begin
      state_q <= ST_WAIT;
      ones_q  <= '0;
      tidx_q  <= '0;
      texp_q  <= '0;
      pay_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ones_q  <= ones_d;
      tidx_q  <= tidx_d;
      texp_q  <= texp_d;
      pay_q   <= pay_d;
      err_q   <= err_d;
    end
  end

  assign done = (state_q == ST_DONE);
  assign err  = err_q;
endmodule

// File: rtl/cfg_chain_rx_chk.sv
module cfg_chain_rx_chk #(
  parameter int NUM_FRAMES = 4,
  parameter int ADDR_W     = 2
) (
  input logic              cclk,
  input logic              prog_n,
  input logic              dout,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              done,
  input logic              err
);
  logic [ADDR_W-1:0] next_addr_q;

  always_ff @(posedge cclk or negedge prog_n) begin
    if (!prog_n)       next_addr_q <= '0;
    else if (wr_valid) next_addr_q <= wr_addr + 1'b1;
  end

  a_r11_done_holds: assert property (@(posedge cclk) disable iff (!prog_n)
    done |=> done);

  a_r11_dout_high_after_done: assert property (@(posedge cclk) disable iff (!prog_n)
    (done && $past(done)) |-> dout);

  a_r7_single_pulse: assert property (@(posedge cclk) disable iff (!prog_n)
    wr_valid |=> !wr_valid);

  a_r7_addr_in_order: assert property (@(posedge cclk) disable iff (!prog_n)
    (wr_valid && !err) |-> (wr_addr == next_addr_q));

  a_r7_addr_range: assert property (@(posedge cclk) disable iff (!prog_n)
    wr_valid |-> (int'(wr_addr) < NUM_FRAMES));

  a_r4_err_sticky: assert property (@(posedge cclk) disable iff (!prog_n)
    err |=> err);
endmodule

bind cfg_chain_rx cfg_chain_rx_chk #(
  .NUM_FRAMES (NUM_FRAMES),
  .ADDR_W     (ADDR_W)
) u_chk (
  .cclk     (cclk),
  .prog_n   (prog_n),
  .dout     (dout),
  .wr_valid (wr_valid),
  .wr_addr  (wr_addr),
  .done     (done),
  .err      (err)
);

// File: tb/cfg_chain_rx_tb_top.sv
`timescale 1ns/1ps
module cfg_chain_rx_tb_top;
  logic        cclk = 1'b0;
  logic        prog_n = 1'b0;
  logic        din = 1'b1;
  logic        dout, wr_valid, done, err;
  logic [1:0]  wr_addr;
  logic [15:0] wr_data;

  always #10 cclk = ~cclk;

  cfg_chain_rx dut_i (
    .cclk(cclk), .prog_n(prog_n), .din(din), .dout(dout),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .done(done), .err(err)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  logic cap_din  [0:255];
  logic cap_dout [0:255];
  logic cap_done [0:255];
  logic cap_err  [0:255];
  int   nb;
  int   wr_cnt;
  int   wr_at  [0:7];
  int   wr_adr [0:7];
  logic [15:0] wr_dat [0:7];
  int   stab_bad;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic begin_stream();
    nb = 0; wr_cnt = 0; stab_bad = 0;
  endtask

  task automatic step(input logic b);
    logic d_before;
    @(negedge cclk); #1;
    if (nb > 0) begin
      cap_dout[nb-1] = dout;
      cap_done[nb-1] = done;
      cap_err[nb-1]  = err;
      if (wr_valid) begin
        if (wr_cnt < 8) begin
          wr_at[wr_cnt]  = nb - 1;
          wr_adr[wr_cnt] = int'(wr_addr);
          wr_dat[wr_cnt] = wr_data;
        end
        wr_cnt++;
      end
    end
    cap_din[nb] = b;
    din = b;
    nb++;
    d_before = dout;
    @(posedge cclk); #1;
    if (dout !== d_before) stab_bad++;
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) step(v[i]);
  endtask

  task automatic send_header(input int lead, input logic [23:0] len);
    repeat (lead) step(1'b1);
    send_bits(32'hF2, 8);
    send_bits({8'h00, len}, 24);
  endtask

  task automatic send_frame(input logic [15:0] d);
    send_bits(32'd0, 2);
    send_bits({16'h0, d}, 16);
  endtask

  task automatic chk_relay(input int lo, input int hi, input string req, input string what);
    int bad = 0;
    for (int i = lo; i <= hi; i++) if (cap_dout[i] !== cap_din[i]) bad++;
    chk(bad == 0, req, what, bad, 0);
  endtask

  task automatic chk_high(input int lo, input int hi, input string req, input string what);
    int bad = 0;
    for (int i = lo; i <= hi; i++) if (cap_dout[i] !== 1'b1) bad++;
    chk(bad == 0, req, what, bad, 0);
  endtask

  // R1: program pulse clears outputs
  task automatic do_reset();
    @(negedge cclk); #1;
    din = 1'b1;
    prog_n = 1'b0;
    #1;
    chk(dout === 1'b1,     "R1", "dout during program", dout, 1);
    chk(done === 1'b0,     "R1", "done during program", done, 0);
    chk(err === 1'b0,      "R1", "err during program", err, 0);
    chk(wr_valid === 1'b0, "R1", "wr_valid during program", wr_valid, 0);
    repeat (2) @(negedge cclk);
    #1 prog_n = 1'b1;
  endtask

  // R2 R3 R5 R6 R7 R9 R10 R11: full chained stream
  task automatic test_full_stream();
    logic [15:0] fr [0:3];
    fr[0] = 16'hA5C3; fr[1] = 16'h0001; fr[2] = 16'h8000; fr[3] = 16'h7E18;
    do_reset();
    begin_stream();
    send_header(3, 24'd92);
    for (int k = 0; k < 4; k++) send_frame(fr[k]);
    send_bits(32'hC3A59, 20);
    send_bits(32'd0, 6);
    step(1'b1);
    chk_relay(0, 34, "R3", "idle and sync bits relayed");
    chk_relay(11, 34, "R5", "length bits relayed");
    chk_high(35, 106, "R6", "dout held high over local frames");
    chk_relay(107, 126, "R9", "overflow bits relayed");
    chk_high(127, 132, "R11", "dout high after done");
    chk(wr_cnt == 4, "R7", "frame write count", wr_cnt, 4);
    for (int k = 0; k < 4; k++) begin
      chk(wr_adr[k] == k, "R7", "write address", wr_adr[k], k);
      chk(wr_dat[k] === fr[k], "R7", "write data", wr_dat[k], fr[k]);
      chk(wr_at[k] == 52 + 18 * k, "R7", "write timing", wr_at[k], 52 + 18 * k);
    end
    chk(cap_done[125] === 1'b0, "R10", "done one bit early", cap_done[125], 0);
    chk(cap_done[126] === 1'b1, "R10", "done at length", cap_done[126], 1);
    chk(done === 1'b1, "R11", "done held", done, 1);
    chk(err === 1'b0, "R3", "no error on clean stream", err, 0);
    chk(stab_bad == 0, "R2", "dout moved at rising edge", stab_bad, 0);
  endtask

  // R4 R10: bad sync tail, then a length ending inside a frame
  task automatic test_bad_sync();
    do_reset();
    begin_stream();
    send_bits(32'b1111_000, 7);
    send_header(2, 24'd10);
    send_bits(32'd0, 2);
    send_bits(32'hA6, 8);
    step(1'b0); step(1'b0); step(1'b1);
    chk(cap_err[5] === 1'b0, "R4", "err before mismatch", cap_err[5], 0);
    chk(cap_err[6] === 1'b1, "R4", "err on mismatch", cap_err[6], 1);
    chk(cap_dout[6] === 1'b0, "R4", "mismatching bit relayed", cap_dout[6], 0);
    chk(cap_done[49] === 1'b0, "R10", "done early mid-frame", cap_done[49], 0);
    chk(cap_done[50] === 1'b1, "R10", "done mid-frame", cap_done[50], 1);
    chk(wr_cnt == 0, "R10", "partial frame not written", wr_cnt, 0);
    chk(err === 1'b1, "R4", "err sticky", err, 1);
    chk_high(51, 52, "R11", "zeros after done hidden");
  endtask

  // R10 R11: zero length
  task automatic test_zero_len();
    do_reset();
    begin_stream();
    send_header(2, 24'd0);
    send_bits(32'd0, 4);
    step(1'b1);
    chk(cap_done[32] === 1'b0, "R10", "done before last length bit", cap_done[32], 0);
    chk(cap_done[33] === 1'b1, "R10", "done on zero length", cap_done[33], 1);
    chk_high(34, 37, "R11", "zeros masked after zero-length done");
    chk(wr_cnt == 0, "R11", "no write after done", wr_cnt, 0);
  endtask

  // R8: start bit of one
  task automatic test_start_err();
    do_reset();
    begin_stream();
    send_header(2, 24'd100);
    step(1'b0); step(1'b1); step(1'b0); step(1'b1);
    chk(cap_err[34] === 1'b0, "R8", "err after good start bit", cap_err[34], 0);
    chk(cap_err[35] === 1'b1, "R8", "err on start bit one", cap_err[35], 1);
    chk(cap_dout[35] === 1'b1, "R6", "bad start bit masked", cap_dout[35], 1);
    chk(cap_dout[36] === 1'b0, "R8", "relay resumes after error", cap_dout[36], 0);
  endtask

  // R1: program during load, then restart from slot 0
  task automatic test_reprogram();
    do_reset();
    begin_stream();
    send_header(2, 24'd92);
    send_frame(16'h1234);
    send_bits(32'h0A, 5);
    do_reset();
    begin_stream();
    send_header(2, 24'd18);
    send_frame(16'h3C96);
    step(1'b1);
    chk(wr_cnt == 1, "R1", "one write after restart", wr_cnt, 1);
    chk(wr_adr[0] == 0, "R1", "restart writes slot 0", wr_adr[0], 0);
    chk(wr_dat[0] === 16'h3C96, "R7", "restart frame data", wr_dat[0], 16'h3C96);
    chk(cap_done[51] === 1'b1, "R10", "done after one-frame length", cap_done[51], 1);
  endtask

  initial begin
    test_full_stream();
    test_bad_sync();
    test_zero_len();
    test_start_err();
    test_reprogram();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule